// File: doc/BRIEF.md
# Partitioned SIMD Add/Subtract and Logic Unit

This block is a 128-bit vector arithmetic unit whose datapath can be cut into lanes of any power-of-two width, from 1 bit up to the whole 128 bits. For addition and subtraction the lane width only decides where the carry chain is broken. Each lane wraps modulo its own width and never saturates. The bitwise AND, OR, XOR and move operations ignore the lane width entirely.

An operation is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. Results are registered. Any operation that is not a 128-bit add or subtract finishes one cycle after acceptance. A 128-bit add or subtract uses one 64-bit half per cycle: the low half and its carry are stored on the accept edge and the upper half completes on the next edge.

A two-state controller handles the split add. ST_IDLE accepts new work. The transition T_WIDE_START leads to ST_UPPER when a 128-bit add or subtract is accepted. ST_UPPER finishes the upper half, holds `in_ready` low, and always takes T_WIDE_END back to ST_IDLE.

Top module: `simd_lane_alu`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_result` is all zeros.
- R2: Opcode 0 (add) with lane code k in 0..6 gives each 2^k-bit lane (a+b) mod 2^k. The lanes are packed from bit 0 upward. The result and `out_valid` appear on the edge after acceptance.
- R3: Opcode 1 (subtract) gives each lane (a-b) mod 2^k. This is done by inverting b and forcing a carry of 1 into the lowest bit of every lane. The timing is the same as R2.
- R4: No carry or borrow crosses a lane boundary. For example, all-ones plus one gives zero in every lane for every lane code.
- R5: Opcodes 2 (AND), 3 (OR), 4 (XOR) and 5 (move, result = operand a) give the same result for every lane code, 0 to 7, and finish one cycle after acceptance.
- R6: Add or subtract with lane code 7 is a single 128-bit operation whose carry passes from bit 63 into bit 64. In the cycle after acceptance, `in_ready` and `out_valid` are both 0. The result and `out_valid` appear on the second edge after acceptance.
- R7: `in_valid` is ignored while `in_ready` is 0. Such an input produces no result and does not alter the pending 128-bit operation.
- R8: Opcodes 6 and 7 are reserved and produce an all-zero result with the normal one-cycle timing.
- R9: `out_valid` is a one-cycle pulse, once per accepted operation. It is never raised when no operation was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 move, 6-7 reserved) |
| in_lw | input | 3 | Lane code: lane width is 2^in_lw bits |
| in_a | input | 128 | Operand a |
| in_b | input | 128 | Operand b |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 128 | Registered result, held until the next one |

## Verification
Every operation except a 128-bit add or subtract is due one edge after it is accepted. A 128-bit add or subtract is due two edges after acceptance, and the edge in between must show `in_ready` and `out_valid` both low. The bench drives inputs on falling edges and samples on the next falling edge, so each check falls in the half cycle after the edge on which the result is due. During the gap cycle of a split add, the bench also drives a decoy request. It then checks that the later result belongs to the first request and that no extra pulse follows it.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int OP_W = 3;
    localparam int LW_W = 3;

    typedef enum logic [OP_W-1:0] {
        OPC_ADD  = 3'd0,
        OPC_SUB  = 3'd1,
        OPC_AND  = 3'd2,
        OPC_OR   = 3'd3,
        OPC_XOR  = 3'd4,
        OPC_MOVE = 3'd5,
        OPC_RSV6 = 3'd6,
        OPC_RSV7 = 3'd7
    } alu_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_UPPER = 1'b1
    } split_state_e;

    function automatic logic is_arith(input logic [OP_W-1:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
    import simd_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            sub,
    input  logic [LW_W-1:0] lw,
    input  logic            chain_en,
    input  logic            chain_cin,
    output logic [W-1:0]    sum,
    output logic            cout
);
    localparam int IW = $clog2(W) + 1;

    logic [IW-1:0] lane_mask;
    logic          c;
    logic          bb;

    // low bits of a position that must be zero at the first bit of a lane
    assign lane_mask = (IW'(1) << lw) - IW'(1);

    always_comb begin
        c   = chain_en ? chain_cin : sub;
        bb  = 1'b0;
        sum = '0;
        for (int i = 0; i < W; i++) begin
            if ((i != 0) && ((IW'(i) & lane_mask) == '0)) begin
                c = sub;
            end
            bb     = b[i] ^ sub;
            sum[i] = a[i] ^ bb ^ c;
            c      = (a[i] & bb) | (a[i] & c) | (bb & c);
        end
        cout = c;
    end

endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit
    import simd_alu_pkg::*;
#(
    parameter int W = 128
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    always_comb begin
        unique case (alu_op_e'(op))
            OPC_AND:  y = a & b;
            OPC_OR:   y = a | b;
            OPC_XOR:  y = a ^ b;
            OPC_MOVE: y = a;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
    import simd_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic wide_req,
    output logic in_ready,
    output logic accept,
    output logic start_wide,
    output logic finish_wide
);
    split_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        in_ready    = 1'b0;
        accept      = 1'b0;
        start_wide  = 1'b0;
        finish_wide = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                accept   = in_valid;
                if (in_valid && wide_req) begin
                    start_wide = 1'b1;
                    state_d    = ST_UPPER;   // T_WIDE_START
                end
            end
            ST_UPPER: begin
                finish_wide = 1'b1;
                state_d     = ST_IDLE;       // T_WIDE_END
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_UPPER_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        start_wide |=> (!in_ready && finish_wide)) else $error("ctrl"); // R6

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [LW_W-1:0]   in_lw,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [LW_W-1:0] FULL_LW = LW_W'($clog2(DATA_W));

    logic              wide_req, accept, start_wide, finish_wide;
    logic              is_sub;
    logic [HALF_W-1:0] lo_sum, hi_sum;
    logic              lo_cout, hi_cout;
    logic [DATA_W-1:0] logic_y;

    // held state for the second half of a split add
    logic [HALF_W-1:0] a_hi_q, b_hi_q, lo_res_q;
    logic              sub_q, carry_q;

    logic [HALF_W-1:0] hi_a, hi_b;
    logic              hi_sub;
    logic [LW_W-1:0]   hi_lw;

    assign is_sub   = (in_op == OPC_SUB);
    assign wide_req = is_arith(in_op) && (in_lw == FULL_LW);

    simd_alu_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .wide_req    (wide_req),
        .in_ready    (in_ready),
        .accept      (accept),
        .start_wide  (start_wide),
        .finish_wide (finish_wide)
    );

    simd_seg_adder #(.W(HALF_W)) u_add_lo (
        .a         (in_a[HALF_W-1:0]),
        .b         (in_b[HALF_W-1:0]),
        .sub       (is_sub),
        .lw        (in_lw),
        .chain_en  (1'b0),
        .chain_cin (1'b0),
        .sum       (lo_sum),
        .cout      (lo_cout)
    );

    always_comb begin
        if (finish_wide) begin
            hi_a   = a_hi_q;
            hi_b   = b_hi_q;
            hi_sub = sub_q;
            hi_lw  = FULL_LW;
        end else begin
            hi_a   = in_a[DATA_W-1:HALF_W];
            hi_b   = in_b[DATA_W-1:HALF_W];
            hi_sub = is_sub;
            hi_lw  = in_lw;
        end
    end

    simd_seg_adder #(.W(HALF_W)) u_add_hi (
        .a         (hi_a),
        .b         (hi_b),
        .sub       (hi_sub),
        .lw        (hi_lw),
        .chain_en  (finish_wide),
        .chain_cin (carry_q),
        .sum       (hi_sum),
        .cout      (hi_cout)
    );

    simd_logic_unit #(.W(DATA_W)) u_logic (
        .op (in_op),
        .a  (in_a),
        .b  (in_b),
        .y  (logic_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_hi_q   <= '0;
            b_hi_q   <= '0;
            lo_res_q <= '0;
            sub_q    <= 1'b0;
            carry_q  <= 1'b0;
        end else if (start_wide) begin
            a_hi_q   <= in_a[DATA_W-1:HALF_W];
            b_hi_q   <= in_b[DATA_W-1:HALF_W];
            lo_res_q <= lo_sum;
            sub_q    <= is_sub;
            carry_q  <= lo_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= (accept && !wide_req) || finish_wide;
            if (finish_wide) begin
                out_result <= {hi_sum, lo_res_q};
            end else if (accept && !wide_req) begin
                if (is_arith(in_op)) out_result <= {hi_sum, lo_sum};
                else                 out_result <= logic_y;
            end
        end
    end

    AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !wide_req) |=> (out_valid && in_ready)) else $error("short"); // R2
    AST_WIDE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && wide_req) |=> (!out_valid && !in_ready)) else $error("gap"); // R6
    AST_WIDE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready) |=> (out_valid && in_ready)) else $error("done"); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !out_valid) else $error("spurious"); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_op == OPC_RSV6 || in_op == OPC_RSV7)) |=> (out_result == '0)) else $error("rsv"); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(out_result)) else $error("hold"); // R9

endmodule

// File: tb/tb_simd_lane_alu.sv
module tb_simd_lane_alu;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_op = '0;
    logic [2:0]   in_lw = '0;
    logic [127:0] in_a = '0;
    logic [127:0] in_b = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    simd_lane_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_lw(in_lw), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [127:0] ref_calc(input logic [2:0] op, input logic [2:0] lw,
                                              input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r, mask, la, lb, s;
        int w, n;
        r = '0;
        case (op)
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = a;
            3'd0, 3'd1: begin
                w = 1 << lw;
                n = 128 / w;
                mask = (w == 128) ? {128{1'b1}} : ((128'd1 << w) - 128'd1);
                for (int l = 0; l < n; l++) begin
                    la = (a >> (l * w)) & mask;
                    lb = (b >> (l * w)) & mask;
                    s  = ((op == 3'd0) ? (la + lb) : (la - lb)) & mask;
                    r  = r | (s << (l * w));
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // drives one operation and checks its result at the due cycle
    task automatic run_op(input logic [2:0] op, input logic [2:0] lw,
                          input logic [127:0] a, input logic [127:0] b, input string req);
        logic [127:0] exp;
        bit wide;
        exp  = ref_calc(op, lw, a, b);
        wide = (lw == 3'd7) && (op <= 3'd1);
        @(negedge clk);
        in_op = op; in_lw = lw; in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        if (wide) begin
            chk(!in_ready && !out_valid, "R6 gap cycle", {126'd0, in_ready, out_valid}, 128'd0);
            // decoy request while not ready (R7)
            in_op = 3'd4; in_lw = 3'd2; in_a = rnd128(); in_b = rnd128();
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid, "R6 valid", {127'd0, out_valid}, 128'd1);
            chk(out_result == exp, req, out_result, exp);
            @(negedge clk);
            chk(!out_valid, "R7 no decoy result", {127'd0, out_valid}, 128'd0);
            chk(out_result == exp, "R7 result kept", out_result, exp);
        end else begin
            in_valid = 1'b0;
            chk(out_valid && in_ready, "R2 one-cycle valid", {126'd0, out_valid, in_ready}, 128'd3);
            chk(out_result == exp, req, out_result, exp);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid && out_result == '0, "R1 reset state", out_result, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 after release", {126'd0, in_ready, out_valid}, 128'd2);

        // R4 directed: all ones + 1 in every lane wraps to zero
        for (int k = 0; k < 8; k++) begin
            logic [127:0] ones_lane;
            ones_lane = '0;
            for (int l = 0; l < (128 >> k); l++) ones_lane[l * (1 << k)] = 1'b1;
            run_op(3'd0, 3'(k), {128{1'b1}}, ones_lane, "R4 lane carry blocked");
            chk(out_result == '0, "R4 zero", out_result, 128'd0);
        end
        // R6 directed: carry across bit 63 and borrow across the middle
        run_op(3'd0, 3'd7, {64'd0, {64{1'b1}}}, 128'd1, "R6 carry into bit 64");
        chk(out_result == {64'd1, 64'd0}, "R6 carry value", out_result, {64'd1, 64'd0});
        run_op(3'd1, 3'd7, 128'd0, 128'd1, "R6 full borrow");
        run_op(3'd1, 3'd6, 128'd0, 128'd1, "R3 64-bit lane borrow");
        // R8 reserved opcodes
        run_op(3'd6, 3'd2, rnd128(), rnd128(), "R8 reserved 6");
        run_op(3'd7, 3'd7, rnd128(), rnd128(), "R8 reserved 7");
        // R9 idle gap: no pulse
        @(negedge clk);
        chk(!out_valid, "R9 no pulse when idle", {127'd0, out_valid}, 128'd0);

        // random sweep over every lane code and opcode
        for (int k = 0; k < 8; k++) begin
            for (int op = 0; op < 6; op++) begin
                for (int it = 0; it < 6; it++) begin
                    string req;
                    req = (op == 0) ? "R2 add" : (op == 1) ? "R3 sub" : "R5 logic";
                    if (k == 7 && op < 2) req = "R6 wide arith";
                    run_op(3'(op), 3'(k), rnd128(), rnd128(), req);
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule